// File: doc/BRIEF.md
# SPI Serial Flash Read Target

This block behaves like the read path of a serial NOR flash on an SPI bus. The host pulls chip select low, shifts in an eight-bit opcode and a 24-bit byte address, and the block then returns bytes from its internal array. It keeps returning bytes for as long as chip select stays low. Two opcodes are recognised: a plain read (0x03) and a fast read (0x0B). The fast read adds one padding byte between the address and the first data byte. The contents of that padding byte are never looked at.

The array holds 2^MEM_AW bytes. A full-size instance uses MEM_AW = 18 (256 KiB), and the default instance is kept small. Address bits at and above MEM_AW are dropped. The read pointer advances after every byte and rolls over from the top address to zero. A preload port in the `clk` domain fills the array before the bus is used. The SPI logic is clocked by `spi_clk` and is cleared asynchronously whenever `spi_cs_n` is high. This lets either SPI mode 0 or mode 3 be used.

Top module: `sfr_flash_read_tgt`

## Requirements
- R1: Opcode 0x03 is followed by 24 address bits. The first data bit appears on `spi_miso` after the falling `spi_clk` edge that follows the 32nd rising edge, and it is valid before the 33rd rising edge.
- R2: Opcode 0x0B is followed by 24 address bits and then 8 padding bits of any value. Data starts after the 40th rising edge, in the same way as R1.
- R3: Opcode, address and data all travel most significant bit first. `spi_mosi` is sampled on rising `spi_clk` edges, and `spi_miso` changes on falling edges.
- R4: While `spi_cs_n` stays low, whole bytes keep streaming out with no gap and no limit on their number.
- R5: The read pointer moves to the next byte after each byte is sent. After address 2^MEM_AW-1 it continues at address 0.
- R6: `spi_miso_oe` is 0 while `spi_cs_n` is high and during the opcode, address and padding bits. It is 1 for every bit of the data phase.
- R7: Any opcode other than 0x03 and 0x0B leaves `spi_miso_oe` at 0 until `spi_cs_n` rises. The transfer after that one is decoded normally.
- R8: A rise of `spi_cs_n` at any bit position ends the transfer at once. `spi_miso_oe` drops, and the next transfer starts again at opcode bit 7.
- R9: Address bits 23 down to MEM_AW have no effect on which byte is read.
- R10: Transfers work with `spi_clk` idling low (mode 0) and with `spi_clk` idling high (mode 3).
- R11: A rising `clk` edge with `pre_we` high stores `pre_data` at `pre_addr`. Later reads of that address return the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Preload clock |
| pre_we | input | 1 | Preload write strobe |
| pre_addr | input | MEM_AW | Preload byte address |
| pre_data | input | 8 | Preload byte value |
| spi_cs_n | input | 1 | Chip select, active low; high clears the bus logic asynchronously |
| spi_clk | input | 1 | SPI serial clock |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the `spi_miso` pad driver |

## Verification
The bench targets the following corner cases:

- **Roll-over at the top of the array.** A pointer that saturates, or that carries into a wider register, would return bytes from the wrong place after the last address.
- **Padding byte of the fast read.** A design that counts the padding byte wrongly would return data shifted by whole bytes. A padding value equal to a valid opcode must change nothing.
- **High address bits.** Addresses with bits set above the array are read; a design that decodes those bits would read elsewhere or fail.
- **Chip select rising mid-byte.** An abort partway through the address tests the asynchronous clear; a stale bit counter would misalign the next opcode.
- **Unknown opcodes and mode 3.** Unknown opcodes must never enable the driver. Mode 3 transfers start with a falling clock edge, and that edge must not be taken as a data bit.

// File: rtl/sfr_pkg.sv
`timescale 1ns/1ps
package sfr_pkg;
   localparam int unsigned SFR_BYTE_W = 8;
   localparam int unsigned SFR_ADDR_W = 24;
   localparam int unsigned SFR_ADDR_BYTES = SFR_ADDR_W / SFR_BYTE_W;

   typedef enum logic [2:0] {
      PH_CMD   = 3'd0,
      PH_ADDR  = 3'd1,
      PH_DUMMY = 3'd2,
      PH_DATA  = 3'd3,
      PH_SKIP  = 3'd4
   } sfr_phase_e;
endpackage

// File: rtl/sfr_array.sv
`timescale 1ns/1ps
module sfr_array #(
   parameter int unsigned MEM_AW = 10,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [MEM_AW-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [MEM_AW-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data
);
   localparam int unsigned DEPTH = 1 << MEM_AW;

   logic [BYTE_W-1:0] cells_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) cells_q[wr_addr] <= wr_data;
   end

   assign rd_data = cells_q[rd_addr];
endmodule

// File: rtl/sfr_rx_fsm.sv
`timescale 1ns/1ps
module sfr_rx_fsm
   import sfr_pkg::*;
#(
   parameter int unsigned MEM_AW   = 10,
   parameter logic [7:0]  OPC_NORM = 8'h03,
   parameter logic [7:0]  OPC_FAST = 8'h0B
) (
   input  logic              spi_clk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output sfr_phase_e        phase,
   output logic [2:0]        bit_cnt,
   output logic [MEM_AW-1:0] rd_ptr
);
   localparam int unsigned AW = SFR_ADDR_W;

   sfr_phase_e        ph_q;
   logic [2:0]        cnt_q;
   logic [1:0]        abyte_q;
   logic              fast_q;
   logic [AW-2:0]     sh_q;
   logic [MEM_AW-1:0] ptr_q;
   logic [AW-1:0]     sh_nx;
   logic [MEM_AW-1:0] addr_cut;
   logic              byte_end;

   assign sh_nx    = {sh_q, spi_mosi};
   assign byte_end = (cnt_q == 3'd7);
   assign addr_cut = sh_nx[MEM_AW-1:0];

   generate
      if (MEM_AW < AW) begin : g_hi_drop
         logic unused_hi;
         assign unused_hi = ^sh_nx[AW-1:MEM_AW];
      end
   endgenerate

   always_ff @(posedge spi_clk or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         ph_q    <= PH_CMD;
         cnt_q   <= 3'd0;
         abyte_q <= 2'd0;
         fast_q  <= 1'b0;
         sh_q    <= '0;
         ptr_q   <= '0;
      end else begin
         cnt_q <= cnt_q + 3'd1;
         sh_q  <= sh_nx[AW-2:0];
         unique case (ph_q)
            PH_CMD: begin
               if (byte_end) begin
                  if (sh_nx[7:0] == OPC_NORM) begin
                     ph_q   <= PH_ADDR;
                     fast_q <= 1'b0;
                  end else if (sh_nx[7:0] == OPC_FAST) begin
                     ph_q   <= PH_ADDR;
                     fast_q <= 1'b1;
                  end else begin
                     ph_q <= PH_SKIP;
                  end
               end
            end
            PH_ADDR: begin
               if (byte_end) begin
                  if (abyte_q == 2'(SFR_ADDR_BYTES - 1)) begin
                     ptr_q <= addr_cut;
                     ph_q  <= fast_q ? PH_DUMMY : PH_DATA;
                  end else begin
                     abyte_q <= abyte_q + 2'd1;
                  end
               end
            end
            PH_DUMMY: begin
               if (byte_end) ph_q <= PH_DATA;
            end
            PH_DATA: begin
               if (byte_end) ptr_q <= ptr_q + MEM_AW'(1);
            end
            default: begin
            end
         endcase
      end
   end

   assign phase   = ph_q;
   assign bit_cnt = cnt_q;
   assign rd_ptr  = ptr_q;
endmodule

// File: rtl/sfr_tx_drv.sv
`timescale 1ns/1ps
module sfr_tx_drv
   import sfr_pkg::*;
(
   input  logic       spi_clk,
   input  logic       spi_cs_n,
   input  sfr_phase_e phase,
   input  logic [2:0] bit_cnt,
   input  logic [7:0] rd_byte,
   output logic       spi_miso,
   output logic       spi_miso_oe
);
   logic so_q;
   logic oe_q;
   logic in_data;

   assign in_data = (phase == PH_DATA);

   always_ff @(negedge spi_clk or posedge spi_cs_n) begin
      if (spi_cs_n) begin
         so_q <= 1'b0;
         oe_q <= 1'b0;
      end else begin
         oe_q <= in_data;
         so_q <= in_data ? rd_byte[3'd7 - bit_cnt] : 1'b0;
      end
   end

   assign spi_miso    = so_q;
   assign spi_miso_oe = oe_q;
endmodule

// File: rtl/sfr_flash_read_tgt.sv
`timescale 1ns/1ps
module sfr_flash_read_tgt
   import sfr_pkg::*;
#(
   parameter int unsigned MEM_AW   = 10,
   parameter logic [7:0]  OPC_NORM = 8'h03,
   parameter logic [7:0]  OPC_FAST = 8'h0B
) (
   input  logic              clk,
   input  logic              pre_we,
   input  logic [MEM_AW-1:0] pre_addr,
   input  logic [7:0]        pre_data,
   input  logic              spi_cs_n,
   input  logic              spi_clk,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe
);
   generate
      if (MEM_AW < 8 || MEM_AW > SFR_ADDR_W) begin : g_bad_aw
         $error("sfr_flash_read_tgt: MEM_AW must lie in 8..24");
      end
      if (OPC_NORM == OPC_FAST) begin : g_bad_opc
         $error("sfr_flash_read_tgt: the two read opcodes must differ");
      end
   endgenerate

   sfr_phase_e        phase;
   logic [2:0]        bit_cnt;
   logic [MEM_AW-1:0] rd_ptr;
   logic [7:0]        rd_byte;

   sfr_array #(
      .MEM_AW (MEM_AW),
      .BYTE_W (SFR_BYTE_W)
   ) u_array (
      .clk     (clk),
      .wr_en   (pre_we),
      .wr_addr (pre_addr),
      .wr_data (pre_data),
      .rd_addr (rd_ptr),
      .rd_data (rd_byte)
   );

   sfr_rx_fsm #(
      .MEM_AW   (MEM_AW),
      .OPC_NORM (OPC_NORM),
      .OPC_FAST (OPC_FAST)
   ) u_rx (
      .spi_clk  (spi_clk),
      .spi_cs_n (spi_cs_n),
      .spi_mosi (spi_mosi),
      .phase    (phase),
      .bit_cnt  (bit_cnt),
      .rd_ptr   (rd_ptr)
   );

   sfr_tx_drv u_tx (
      .spi_clk     (spi_clk),
      .spi_cs_n    (spi_cs_n),
      .phase       (phase),
      .bit_cnt     (bit_cnt),
      .rd_byte     (rd_byte),
      .spi_miso    (spi_miso),
      .spi_miso_oe (spi_miso_oe)
   );
endmodule

// File: rtl/sfr_read_chk.sv
`timescale 1ns/1ps
module sfr_read_chk
   import sfr_pkg::*;
#(
   parameter int unsigned MEM_AW = 10
) (
   input logic              spi_clk,
   input logic              spi_cs_n,
   input logic              spi_miso_oe,
   input sfr_phase_e        phase,
   input logic [2:0]        bit_cnt,
   input logic [MEM_AW-1:0] rd_ptr
);
   logic live_q;

   always_ff @(posedge spi_clk or posedge spi_cs_n) begin
      if (spi_cs_n) live_q <= 1'b0;
      else          live_q <= 1'b1;
   end

   // R6
   oe_only_data_chk: assert property (@(posedge spi_clk) disable iff (spi_cs_n)
      spi_miso_oe |-> (phase == PH_DATA));

   // R7
   skip_sticky_chk: assert property (@(posedge spi_clk) disable iff (spi_cs_n)
      (phase == PH_SKIP) |=> (!live_q || phase == PH_SKIP));

   // R5
   ptr_step_chk: assert property (@(posedge spi_clk) disable iff (spi_cs_n)
      (phase == PH_DATA && bit_cnt == 3'd7)
      |=> (!live_q || rd_ptr == MEM_AW'($past(rd_ptr) + MEM_AW'(1))));

   // R3
   data_align_chk: assert property (@(posedge spi_clk) disable iff (spi_cs_n)
      (live_q && phase == PH_DATA && $past(phase) != PH_DATA) |-> (bit_cnt == 3'd0));
endmodule

bind sfr_flash_read_tgt sfr_read_chk #(.MEM_AW(MEM_AW)) u_chk (
   .spi_clk     (spi_clk),
   .spi_cs_n    (spi_cs_n),
   .spi_miso_oe (spi_miso_oe),
   .phase       (phase),
   .bit_cnt     (bit_cnt),
   .rd_ptr      (rd_ptr)
);

// File: tb/sim_sfr_flash_read_tgt.sv
`timescale 1ns/1ps
module sim_sfr_flash_read_tgt;
   localparam int MEM_AW = 10;
   localparam int DEPTH  = 1 << MEM_AW;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              pre_we   = 1'b0;
   logic [MEM_AW-1:0] pre_addr = '0;
   logic [7:0]        pre_data = '0;
   logic              spi_cs_n = 1'b1;
   logic              spi_clk  = 1'b0;
   logic              spi_mosi = 1'b0;
   logic              spi_miso;
   logic              spi_miso_oe;

   int   checks = 0;
   int   fails  = 0;
   bit   finished = 1'b0;
   logic [7:0] ref_mem [DEPTH];

   sfr_flash_read_tgt #(.MEM_AW(MEM_AW)) u0 (
      .clk         (clk),
      .pre_we      (pre_we),
      .pre_addr    (pre_addr),
      .pre_data    (pre_data),
      .spi_cs_n    (spi_cs_n),
      .spi_clk     (spi_clk),
      .spi_mosi    (spi_mosi),
      .spi_miso    (spi_miso),
      .spi_miso_oe (spi_miso_oe)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_byte(input logic [23:0] adr, input int k);
      return ref_mem[(int'(adr[MEM_AW-1:0]) + k) % DEPTH];
   endfunction

   task automatic preload(input int a, input logic [7:0] d);
      @(negedge clk);
      pre_we = 1'b1; pre_addr = MEM_AW'(a); pre_data = d;
      @(negedge clk);
      pre_we = 1'b0;
      ref_mem[a] = d;
   endtask

   task automatic spi_bit(input logic mo, output logic mi, output logic oe);
      spi_clk = 1'b0; #20;
      spi_mosi = mo;  #20;
      mi = spi_miso; oe = spi_miso_oe;
      spi_clk = 1'b1; #40;
   endtask

   task automatic spi_start(input bit m3);
      spi_clk = m3; #40;
      spi_cs_n = 1'b0; #20;
   endtask

   task automatic spi_stop(input bit m3);
      if (!m3) begin spi_clk = 1'b0; #20; end
      spi_cs_n = 1'b1; #5;
      check(spi_miso_oe == 1'b0, "R8 oe after cs high", spi_miso_oe, 0);
      #35;
   endtask

   task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, output bit oe_all, output bit oe_any);
      logic b, o;
      rx = '0; oe_all = 1'b1; oe_any = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         spi_bit(tx[i], b, o);
         rx[i] = b;
         oe_all = oe_all & o;
         oe_any = oe_any | o;
      end
   endtask

   task automatic do_read(input logic [7:0] opc, input logic [23:0] adr, input logic [7:0] pad,
                          input int n, input bit m3, input string tag);
      logic [7:0] rx;
      bit oa, oy, hdr_quiet;
      hdr_quiet = 1'b1;
      spi_start(m3);
      spi_byte(opc, rx, oa, oy);         hdr_quiet &= !oy;
      spi_byte(adr[23:16], rx, oa, oy);  hdr_quiet &= !oy;
      spi_byte(adr[15:8], rx, oa, oy);   hdr_quiet &= !oy;
      spi_byte(adr[7:0], rx, oa, oy);    hdr_quiet &= !oy;
      if (opc == 8'h0B) begin
         spi_byte(pad, rx, oa, oy);      hdr_quiet &= !oy;
      end
      check(hdr_quiet, {"R6 header quiet ", tag}, !hdr_quiet, 0);
      for (int k = 0; k < n; k++) begin
         spi_byte(8'($urandom), rx, oa, oy);
         check(rx == exp_byte(adr, k) && oa, {"R1/R2/R3/R4 data ", tag},
               {23'd0, oa, rx}, {24'd1, exp_byte(adr, k)});
      end
      spi_stop(m3);
   endtask

   initial begin
      #3_000_000;
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] rx;
      bit oa, oy, quiet;
      int unsigned seedv;
      seedv = $urandom(32'd20240611);
      #50;
      // R6: idle state with chip select high
      check(spi_miso_oe == 1'b0, "R6 reset oe", spi_miso_oe, 0);

      // R11: fill array
      for (int a = 0; a < DEPTH; a++) preload(a, 8'($urandom));

      // R1: plain read, mode 0
      do_read(8'h03, 24'h000010, 8'h00, 4, 1'b0, "R1 plain");
      // R2: fast read, padding equal to an opcode
      do_read(8'h0B, 24'h000123, 8'h03, 4, 1'b0, "R2 fast");
      // R5: roll-over at top address
      do_read(8'h03, 24'(DEPTH - 2), 8'h00, 5, 1'b0, "R5 wrap");
      do_read(8'h0B, 24'(DEPTH - 1), 8'hFF, 3, 1'b1, "R5 wrap fast");
      // R9: high address bits ignored
      do_read(8'h03, 24'hFFFC05, 8'h00, 3, 1'b0, "R9 high bits");
      do_read(8'h0B, 24'hA5A300, 8'h5A, 2, 1'b1, "R9 high bits fast");
      // R10: mode 3
      do_read(8'h03, 24'h000200, 8'h00, 3, 1'b1, "R10 mode3");
      // R4: long stream
      do_read(8'h03, 24'h000300, 8'h00, 40, 1'b0, "R4 long");

      // R7: unknown opcode keeps driver off
      spi_start(1'b0);
      quiet = 1'b1;
      spi_byte(8'h5A, rx, oa, oy); quiet &= !oy;
      for (int j = 0; j < 5; j++) begin spi_byte(8'h03, rx, oa, oy); quiet &= !oy; end
      check(quiet, "R7 unknown opcode", !quiet, 0);
      spi_stop(1'b0);
      do_read(8'h03, 24'h000040, 8'h00, 2, 1'b0, "R7 after unknown");

      // R8: abort mid address byte
      spi_start(1'b1);
      spi_byte(8'h0B, rx, oa, oy);
      spi_byte(8'h00, rx, oa, oy);
      for (int j = 0; j < 3; j++) spi_bit(1'b1, oa, oy);
      spi_stop(1'b1);
      do_read(8'h03, 24'h000077, 8'h00, 2, 1'b0, "R8 after abort");

      // R11: rewrite then read back
      preload(9, 8'hC3);
      preload(10, 8'h3C);
      do_read(8'h03, 24'h000009, 8'h00, 2, 1'b0, "R11 rewrite");

      // random bursts
      for (int it = 0; it < 24; it++) begin
         logic [7:0] opc;
         opc = ($urandom % 2 == 0) ? 8'h03 : 8'h0B;
         do_read(opc, 24'($urandom), 8'($urandom), 1 + int'($urandom % 5),
                 bit'($urandom % 2), "R1/R2/R10 random");
      end

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule